// File: doc/BRIEF.md
# Load Result Aligner and Extender

This block turns a raw 64-bit word fetched for a load into the value written to the destination register. The low three bits of the load's physical address give the byte offset inside the 8-byte word. The word is shifted right by that many bytes, so the addressed byte sits at bit 0, and zeros fill the vacated upper bytes. The shifted value is then cut down to the access size. Depending on the operation, the upper bits are filled with copies of the sign bit, with zeros, or with ones. Filling with ones NaN-boxes a single-precision value bound for a floating-point register.

The block has a small decoder and a datapath. The decoder turns the 3-bit operation code and the floating-point flag into a set of control strobes. The datapath does the shift, the narrowing and the fill. A parameter chooses whether the result is registered once or leaves combinationally. Accesses that cross the 8-byte word are out of scope, and so is exception reporting.

Top module: `loadAlignExt`

## Requirements
- R1: The byte offset `addrOffset` (address bits [2:0]) shifts `rawWord` right by 8 × offset bits, with zeros filling the vacated high bits, before any narrowing.
- R2: Operation code 0 (signed byte) sign-extends bits [7:0] of the shifted word to 64 bits.
- R3: Operation code 1 (signed halfword) sign-extends bits [15:0] of the shifted word to 64 bits.
- R4: Operation codes 4, 5 and 6 (unsigned byte, halfword, word) zero-extend bits [7:0], [15:0] and [31:0] of the shifted word respectively.
- R5: Operation code 2 (word) with `fpDest` = 0 sign-extends bits [31:0] of the shifted word.
- R6: Operation code 2 with `fpDest` = 1 keeps bits [31:0] of the shifted word and sets bits [63:32] to all ones.
- R7: Operation code 3 (double) returns the whole shifted word unchanged, whatever the value of `fpDest`.
- R8: Operation code 7 gives a result of zero.
- R9: `fpDest` has no effect on the result for codes 0, 1, 4, 5, 6 and 7.
- R10: With `OUT_REG` = 1, `result` holds zero while `rstN` is low. It shows the value for the inputs sampled at a rising edge of `clk` after that edge. With `OUT_REG` = 0, it follows the inputs directly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Active-low asynchronous reset of the output register |
| rawWord | input | 64 | Raw data word from the load buffer |
| addrOffset | input | 3 | Byte offset inside the word (address bits [2:0]) |
| opType | input | 3 | Operation code: 0 sb, 1 sh, 2 w, 3 d, 4 ub, 5 uh, 6 uw, 7 none |
| fpDest | input | 1 | Destination is a floating-point register |
| result | output | 64 | Aligned and extended writeback value |

## Verification
A wrong decode strobe shows up in the upper bits of `result`. A sign fill where a zero fill belongs, or a missing NaN box, corrupts bits [63:8], [63:16] or [63:32] one cycle after the inputs are presented, or at once when `OUT_REG` is 0. A wrong shifter stage misplaces whole bytes, but only for offsets that have that offset bit set. The bench therefore sweeps every offset against every operation code, with both values of the floating-point flag, for data patterns whose sign bits differ by byte.

// File: rtl/loadAlignExt_pkg.sv
package loadAlignExt_pkg;

  typedef enum logic [2:0] {
    OP_SB   = 3'd0,
    OP_SH   = 3'd1,
    OP_SW   = 3'd2,
    OP_D    = 3'd3,
    OP_UB   = 3'd4,
    OP_UH   = 3'd5,
    OP_UW   = 3'd6,
    OP_NONE = 3'd7
  } loadOp_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } accSize_e;

  typedef struct packed {
    accSize_e sizeSel;
    logic     signFill;
    logic     onesFill;
    logic     forceZero;
  } extCtrl_t;

endpackage

// File: rtl/loadAlignExt_ctrl.sv
module loadAlignExt_ctrl
  import loadAlignExt_pkg::*;
(
  input  logic [2:0] opType,
  input  logic       fpDest,
  output extCtrl_t   ctrl
);

  always_comb begin
    ctrl = '{sizeSel: SZ_DBL, signFill: 1'b0, onesFill: 1'b0, forceZero: 1'b0};
    unique case (loadOp_e'(opType))
      OP_SB: begin ctrl.sizeSel = SZ_BYTE; ctrl.signFill = 1'b1; end
      OP_SH: begin ctrl.sizeSel = SZ_HALF; ctrl.signFill = 1'b1; end
      OP_SW: begin
        ctrl.sizeSel  = SZ_WORD;
        ctrl.signFill = !fpDest;
        ctrl.onesFill = fpDest;
      end
      OP_D:  ctrl.sizeSel = SZ_DBL;
      OP_UB: ctrl.sizeSel = SZ_BYTE;
      OP_UH: ctrl.sizeSel = SZ_HALF;
      OP_UW: ctrl.sizeSel = SZ_WORD;
      default: ctrl.forceZero = 1'b1;
    endcase
  end

endmodule

// File: rtl/loadAlignExt_dp.sv
module loadAlignExt_dp
  import loadAlignExt_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES)
) (
  input  logic [DATA_W-1:0] rawWord,
  input  logic [OFF_W-1:0]  addrOffset,
  input  extCtrl_t          ctrl,
  output logic [DATA_W-1:0] alignedVal
);

  // Logarithmic right shifter: stage k moves the word by 2^k bytes
  logic [DATA_W-1:0] stageVal [OFF_W+1];
  assign stageVal[0] = rawWord;

  for (genvar k = 0; k < OFF_W; k++) begin : g_shift
    localparam int SHAMT = 8 * (1 << k);
    assign stageVal[k+1] = addrOffset[k] ? (stageVal[k] >> SHAMT) : stageVal[k];
  end

  logic [DATA_W-1:0] shifted;
  assign shifted = stageVal[OFF_W];

  // Per-byte keep mask derived from the access size
  logic [BYTES-1:0] keepByte;
  for (genvar b = 0; b < BYTES; b++) begin : g_keep
    assign keepByte[b] = (b < (1 << ctrl.sizeSel));
  end

  logic [DATA_W-1:0] keepMask;
  for (genvar b = 0; b < BYTES; b++) begin : g_mask
    assign keepMask[8*b +: 8] = {8{keepByte[b]}};
  end

  logic topBit;
  always_comb begin
    unique case (ctrl.sizeSel)
      SZ_BYTE: topBit = shifted[7];
      SZ_HALF: topBit = shifted[15];
      SZ_WORD: topBit = shifted[31];
      default: topBit = shifted[DATA_W-1];
    endcase
  end

  logic fillBit;
  assign fillBit = ctrl.onesFill | (ctrl.signFill & topBit);

  always_comb begin
    if (ctrl.forceZero) alignedVal = '0;
    else alignedVal = (shifted & keepMask) | ({DATA_W{fillBit}} & ~keepMask);
  end

endmodule

// File: rtl/loadAlignExt.sv
module loadAlignExt
  import loadAlignExt_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter bit OUT_REG = 1'b1,
  localparam int OFF_W = $clog2(DATA_W / 8)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] rawWord,
  input  logic [OFF_W-1:0]  addrOffset,
  input  logic [2:0]        opType,
  input  logic              fpDest,
  output logic [DATA_W-1:0] result
);

  extCtrl_t          ctrl;
  logic [DATA_W-1:0] alignedVal;

  loadAlignExt_ctrl u_ctrl (
    .opType (opType),
    .fpDest (fpDest),
    .ctrl   (ctrl)
  );

  loadAlignExt_dp #(.DATA_W(DATA_W)) u_dp (
    .rawWord    (rawWord),
    .addrOffset (addrOffset),
    .ctrl       (ctrl),
    .alignedVal (alignedVal)
  );

  if (OUT_REG) begin : g_reg
    logic [DATA_W-1:0] resultQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) resultQ <= '0;
      else       resultQ <= alignedVal;
    end
    assign result = resultQ;
  end else begin : g_comb
    assign result = alignedVal;
  end

endmodule

// File: rtl/loadAlignExt_chk.sv
module loadAlignExt_chk #(
  parameter int DATA_W  = 64,
  parameter bit OUT_REG = 1'b1,
  localparam int OFF_W = $clog2(DATA_W / 8)
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] rawWord,
  input logic [OFF_W-1:0]  addrOffset,
  input logic [2:0]        opType,
  input logic              fpDest,
  input logic [DATA_W-1:0] result
);

  logic [DATA_W-1:0] dRaw;
  logic [OFF_W-1:0]  dOff;
  logic [2:0]        dOp;
  logic              dFp;
  logic              primed;

  if (OUT_REG) begin : g_dly
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dRaw <= '0; dOff <= '0; dOp <= '0; dFp <= 1'b0; primed <= 1'b0;
      end else begin
        dRaw <= rawWord; dOff <= addrOffset; dOp <= opType; dFp <= fpDest;
        primed <= 1'b1;
      end
    end
  end else begin : g_dir
    assign dRaw = rawWord;
    assign dOff = addrOffset;
    assign dOp = opType;
    assign dFp = fpDest;
    assign primed = 1'b1;
  end

  p_zero_code_r8: assert property (@(posedge clk) disable iff (!rstN)
    (primed && dOp == 3'd7) |-> (result == '0));

  p_nanbox_r6: assert property (@(posedge clk) disable iff (!rstN)
    (primed && dOp == 3'd2 && dFp) |-> (result[DATA_W-1:32] == '1));

  p_word_sign_r5: assert property (@(posedge clk) disable iff (!rstN)
    (primed && dOp == 3'd2 && !dFp) |-> (result[DATA_W-1:32] == {(DATA_W-32){result[31]}}));

  p_byte_sign_r2: assert property (@(posedge clk) disable iff (!rstN)
    (primed && dOp == 3'd0) |-> (result[DATA_W-1:8] == {(DATA_W-8){result[7]}}));

  p_half_sign_r3: assert property (@(posedge clk) disable iff (!rstN)
    (primed && dOp == 3'd1) |-> (result[DATA_W-1:16] == {(DATA_W-16){result[15]}}));

  p_unsigned_byte_r4: assert property (@(posedge clk) disable iff (!rstN)
    (primed && dOp == 3'd4) |-> (result[DATA_W-1:8] == '0));

  p_double_pass_r7: assert property (@(posedge clk) disable iff (!rstN)
    (primed && dOp == 3'd3 && dOff == '0) |-> (result == dRaw));

  p_top_zero_fill_r1: assert property (@(posedge clk) disable iff (!rstN)
    (primed && dOp == 3'd3 && dOff == 3'd7) |-> (result[DATA_W-1:8] == '0));

endmodule

bind loadAlignExt loadAlignExt_chk #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .rawWord    (rawWord),
  .addrOffset (addrOffset),
  .opType     (opType),
  .fpDest     (fpDest),
  .result     (result)
);

// File: tb/loadAlignExt_test.sv
module loadAlignExt_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] rawWord = '0;
  logic [2:0]  addrOffset = '0;
  logic [2:0]  opType = '0;
  logic        fpDest = 1'b0;
  logic [63:0] result;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  loadAlignExt #(.DATA_W(64), .OUT_REG(1'b1)) uut (
    .clk(clk), .rstN(rstN), .rawWord(rawWord), .addrOffset(addrOffset),
    .opType(opType), .fpDest(fpDest), .result(result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference: shift, mask, then fill
  function automatic logic [63:0] refModel(input logic [63:0] w, input int off,
                                          input int op, input bit fp);
    logic [63:0] s, m;
    bit sgn, ones;
    s = w >> (8 * off);
    ones = 1'b0;
    case (op)
      0: begin m = 64'hFF;        sgn = 1'b1; end
      1: begin m = 64'hFFFF;      sgn = 1'b1; end
      2: begin m = 64'hFFFF_FFFF; sgn = !fp; ones = fp; end
      3: begin m = '1;            sgn = 1'b0; end
      4: begin m = 64'hFF;        sgn = 1'b0; end
      5: begin m = 64'hFFFF;      sgn = 1'b0; end
      6: begin m = 64'hFFFF_FFFF; sgn = 1'b0; end
      default: return 64'h0;
    endcase
    if (ones || (sgn && ((s & ~(m >> 1) & m) != 0))) return (s & m) | ~m;
    return s & m;
  endfunction

  function automatic string reqOf(input int op, input bit fp);
    case (op)
      0: return "R2";
      1: return "R3";
      2: return fp ? "R6" : "R5";
      3: return "R7";
      7: return "R8";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : stim
    logic [63:0] pats [4];
    logic [63:0] expPrev;
    logic [63:0] fpPair [2];
    bit havePrev;
    string reqPrev;
    pats[0] = 64'h8081_8283_F4F5_F6F7;
    pats[1] = 64'h0123_4567_89AB_CDEF;
    pats[2] = 64'h7F00_807F_0080_FF01;
    pats[3] = 64'hFEDC_BA98_7654_3210;
    havePrev = 1'b0;
    expPrev = '0;
    reqPrev = "";

    // R10: reset holds result at zero
    rawWord = 64'hFFFF_FFFF_FFFF_FFFF; opType = 3'd3;
    repeat (3) @(negedge clk);
    check("R10", result, 64'h0);
    rstN = 1'b1;

    for (int p = 0; p < 4; p++) begin
      for (int off = 0; off < 8; off++) begin
        for (int op = 0; op < 8; op++) begin
          for (int fp = 0; fp < 2; fp++) begin
            @(negedge clk);
            if (havePrev) check(reqPrev, result, expPrev);
            rawWord = pats[p]; addrOffset = 3'(off); opType = 3'(op); fpDest = fp[0];
            expPrev = refModel(pats[p], off, op, fp[0]);
            reqPrev = (off != 0 && op == 3) ? "R1" : reqOf(op, fp[0]);
            havePrev = 1'b1;
            // R10: output not updated before the clock edge
            if (p == 0 && off == 1 && op == 7 && fp == 0) check("R10", result, refModel(pats[0], 1, 6, 1'b1));
          end
        end
      end
    end
    @(negedge clk);
    check(reqPrev, result, expPrev);

    // R9: flag ignored for non-word/double codes, compared at the port
    for (int op = 0; op < 8; op++) begin
      if (op == 2 || op == 3) continue;
      for (int fp = 0; fp < 2; fp++) begin
        rawWord = 64'hC3A5_96E1_8F7E_B4D2; addrOffset = 3'd3; opType = 3'(op); fpDest = fp[0];
        @(negedge clk);
        fpPair[fp] = result;
      end
      check("R9", fpPair[1], fpPair[0]);
    end

    // R7: double ignores the flag
    rawWord = 64'h8000_0000_0000_0001; addrOffset = 3'd0; opType = 3'd3; fpDest = 1'b1;
    @(negedge clk);
    check("R7", result, 64'h8000_0000_0000_0001);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule